// File: doc/BRIEF.md
# Successive Approximation Converter Controller

This block holds the digital control and register logic of a successive-approximation analog-to-digital converter. The data path is 16 bits wide by default. A single convert line serves two roles. While the line is high, the block is held cleared. When the line falls, a conversion starts. During a conversion the block makes one bit decision per clock, from the most significant bit down. On each decision it drives a trial word to an external DAC. It keeps the trial bit only when the comparator reports that the input is at or above the DAC level.

The finished word appears on a parallel port as a complemented code, so a logic 0 marks a true 1. The same decisions leave the block one by one on a complemented NRZ serial line while the conversion runs. A strobe that changes level once per decision goes with the serial line. A busy flag covers the whole conversion.

A two-bit resolution select can end the conversion early, after 14, 13 or 12 bits. A two's-complement view of the parallel word is also available: it inverts that word's top bit.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A conversion starts when `conv_i` is sampled low at a rising clock edge after being sampled high at the previous edge. `busy_o` reads 1 from that edge on.
- R2: At every edge where `conv_i` is sampled high, the block returns to idle, which aborts any conversion in progress. After such an edge, `busy_o` is 0, `ser_o` is 1, `sclk_o` is 0 and the stored result is all ones.
- R3: A high pulse on `conv_i` that covers no rising clock edge has no effect, and `busy_o` stays 0.
- R4: The decision for bit k is made in the k-th cycle after the start edge, counting bits from the MSB. During that cycle `trial_o` equals the bits already decided, plus bit k set to 1, with all lower bits 0. The bit is kept when `comp_i` is 1.
- R5: For an n-bit conversion, `busy_o` stays high for exactly n+1 cycles. When it falls, `data_o` holds the bitwise complement of the decided word.
- R6: `res_sel_i` is latched at the start edge. Its values mean: 0 gives 16 bits, 1 gives 14, 2 gives 13 and 3 gives 12. Bits below the selected LSB are never tried, and they read 1 on `data_o`.
- R7: In the cycle right after the start edge, `ser_o` is 1. In each later busy cycle, `ser_o` carries the complement of the bit decided at the edge just before, MSB first. While idle, `ser_o` is 1.
- R8: At the start edge, `sclk_o` is set to 0. It then toggles once at each decision edge. It does not change when the last busy cycle ends, and it does not change while idle.
- R9: When `ctc_i` is 1, bit 15 of `data_o` is inverted. `ctc_i` has no effect on `ser_o`.
- R10: Once `busy_o` falls, `data_o` keeps its value, whatever `comp_i` does, until `conv_i` is sampled high or `rst_ni` is asserted.
- R11: While `rst_ni` is low, the block is forced to idle at once, without waiting for a clock. In that state `busy_o` is 0, `data_o` is all ones (with `ctc_i` at 0), `ser_o` is 1 and `sclk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Decision clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Convert line: high clears the block, falling edge starts a conversion |
| comp_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| res_sel_i | input | 2 | Resolution: 0 = 16 bits, 1 = 14, 2 = 13, 3 = 12 |
| ctc_i | input | 1 | Invert the top bit of the parallel result |
| trial_o | output | 16 | Trial word driven to the DAC |
| data_o | output | 16 | Complemented parallel result |
| ser_o | output | 1 | Complemented serial bit, MSB first |
| sclk_o | output | 1 | Strobe that toggles once per bit decision |
| busy_o | output | 1 | High while a conversion is in progress |

## Verification
The comparator is modelled as an ideal threshold against a stimulus code, and each conversion is tested against that code.

- The codes 0x0000 and 0xFFFF test the two ends of the range: a trial bit that is never kept, and one that is always kept.
- The codes 0x8000 and 0x7FFF test a boundary that is decided entirely by the MSB.
- The mixed pattern 0x9896 shows that each decision is made on its own, bit by bit.
- Short-cycled runs at 14, 13 and 12 bits compare the truncated word, the shorter busy time, and the forced lower bits.
- Runs with `ctc_i` set show that only the parallel MSB changes.
- Directed cases cover an abort in the middle of a conversion, a command pulse that falls between two clock edges, an asynchronous reset, and a result held stable while `comp_i` keeps changing.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_LAST} sar_state_e;

  // position of the last decided bit for a resolution code
  function automatic int unsigned lsb_pos(input logic [1:0] sel, input int unsigned width);
    case (sel)
      2'd1:    return width - 14;
      2'd2:    return width - 13;
      2'd3:    return width - 12;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/sar_cmd.sv
module sar_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_i,
  output logic start_o,
  output logic hold_o
);
  logic conv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_q <= 1'b0;
    else         conv_q <= conv_i;
  end

  assign start_o = conv_q & ~conv_i;
  assign hold_o  = conv_i;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hold_i,
  input  logic             comp_i,
  input  logic [1:0]       res_sel_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o,
  output logic             busy_o,
  output logic             dec_o,
  output logic             bit_o
);
  localparam int unsigned IW = $clog2(WIDTH);

  sar_state_e       state_q;
  logic [IW-1:0]    idx_q, lsb_q;
  logic [WIDTH-1:0] sar_q, res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      lsb_q   <= '0;
      sar_q   <= '0;
      res_q   <= '1;
    end else if (hold_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      lsb_q   <= '0;
      sar_q   <= '0;
      res_q   <= '1;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CONV;
          idx_q   <= IW'(WIDTH - 1);
          lsb_q   <= IW'(lsb_pos(res_sel_i, WIDTH));
          sar_q   <= '0;
        end
        ST_CONV: begin
          sar_q[idx_q] <= comp_i;
          if (idx_q == lsb_q) state_q <= ST_LAST;
          else                idx_q   <= idx_q - 1'b1;
        end
        default: begin
          res_q   <= ~sar_q;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    trial_o = sar_q;
    if (state_q == ST_CONV) trial_o[idx_q] = 1'b1;
  end

  assign result_o = res_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign dec_o    = (state_q == ST_CONV);
  assign bit_o    = comp_i;
endmodule

// File: rtl/sar_ser.sv
module sar_ser (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hold_i,
  input  logic dec_i,
  input  logic bit_i,
  input  logic busy_i,
  output logic ser_o,
  output logic sclk_o
);
  logic ser_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else if (hold_i || start_i) begin
      ser_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else if (dec_i) begin
      ser_q  <= ~bit_i;
      sclk_q <= ~sclk_q;
    end
  end

  assign ser_o  = busy_i ? ser_q : 1'b1;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic             comp_i,
  input  logic [1:0]       res_sel_i,
  input  logic             ctc_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] data_o,
  output logic             ser_o,
  output logic             sclk_o,
  output logic             busy_o
);
  logic             start, hold, dec, dbit;
  logic [WIDTH-1:0] result;

  sar_cmd u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .conv_i(conv_i),
    .start_o(start), .hold_o(hold)
  );

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .hold_i(hold),
    .comp_i(comp_i), .res_sel_i(res_sel_i), .trial_o(trial_o),
    .result_o(result), .busy_o(busy_o), .dec_o(dec), .bit_o(dbit)
  );

  sar_ser u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .hold_i(hold),
    .dec_i(dec), .bit_i(dbit), .busy_i(busy_o),
    .ser_o(ser_o), .sclk_o(sclk_o)
  );

  assign data_o = result ^ {ctc_i, {(WIDTH-1){1'b0}}};
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             conv_i,
  input logic             ctc_i,
  input logic [WIDTH-1:0] data_o,
  input logic             ser_o,
  input logic             sclk_o,
  input logic             busy_o
);
  assert_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_i && $past(conv_i) && $past(rst_ni)) |=> busy_o);

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_i |=> (!busy_o && ser_o && !sclk_o));

  assert_ser_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ser_o);

  assert_sclk_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o) && $past(!conv_i)) |-> $stable(sclk_o));

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o) && $past(!conv_i) && $stable(ctc_i)) |-> $stable(data_o));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .conv_i(conv_i), .ctc_i(ctc_i),
  .data_o(data_o), .ser_o(ser_o), .sclk_o(sclk_o), .busy_o(busy_o)
);

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        conv_i = 1'b0;
  logic [1:0]  res_sel_i = 2'd0;
  logic        ctc_i = 1'b0;
  logic [15:0] code_r = 16'h0000;
  logic [15:0] trial_o, data_o;
  logic        ser_o, sclk_o, busy_o, comp_i;
  int          n_checks = 0;
  int          n_err = 0;

  always #2 clk_i = ~clk_i;

  // ideal comparator
  assign comp_i = (code_r >= trial_o);

  sar_adc_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .conv_i(conv_i), .comp_i(comp_i),
    .res_sel_i(res_sel_i), .ctc_i(ctc_i), .trial_o(trial_o), .data_o(data_o),
    .ser_o(ser_o), .sclk_o(sclk_o), .busy_o(busy_o)
  );

  localparam int NV = 8;
  localparam logic [15:0] V_CODE [NV] = '{16'h9896, 16'h0000, 16'hFFFF, 16'h8000,
                                          16'h7FFF, 16'hABCD, 16'h1234, 16'hFFFF};
  localparam logic [1:0]  V_SEL  [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd3};
  localparam logic        V_CTC  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [15:0] code, input logic [1:0] sel, input logic ctc);
    int nbits, cnt, bad_ser, bad_sclk, bad_trial;
    logic [15:0] mask, expw, t_exp;
    code_r = code; res_sel_i = sel; ctc_i = ctc;
    nbits = (sel == 2'd0) ? 16 : (sel == 2'd1) ? 14 : (sel == 2'd2) ? 13 : 12;
    mask = 16'hFFFF << (16 - nbits);
    expw = code & mask;
    @(negedge clk_i) conv_i = 1'b1;
    @(negedge clk_i) conv_i = 1'b0;
    @(negedge clk_i);
    cnt = 0; bad_ser = 0; bad_sclk = 0; bad_trial = 0;
    while (busy_o && cnt < 40) begin
      cnt++;
      if (cnt == 1) begin
        if (ser_o !== 1'b1) bad_ser++;
      end else if (ser_o !== ~expw[17-cnt]) bad_ser++;
      if (sclk_o !== 1'((cnt - 1) & 1)) bad_sclk++;
      if (cnt <= nbits) begin
        t_exp = (expw & ~16'((32'd1 << (17 - cnt)) - 1)) | 16'(32'd1 << (16 - cnt));
        if (trial_o !== t_exp) bad_trial++;
      end
      @(negedge clk_i);
    end
    check(cnt == nbits + 1, "R5/R6 busy length", 32'(cnt), 32'(nbits + 1));
    check(data_o === (~expw ^ {ctc, 15'b0}), "R5/R6/R9 parallel result", 32'(data_o), 32'(~expw ^ {ctc, 15'b0}));
    check(bad_trial == 0, "R4 trial sequence", 32'(bad_trial), 0);
    check(bad_ser == 0 && ser_o === 1'b1, "R7/R9 serial stream", 32'(bad_ser), 0);
    check(bad_sclk == 0, "R8 strobe toggling", 32'(bad_sclk), 0);
  endtask

  initial begin
    #(4 * 100000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    int bad;
    #5;
    // R11 reset state
    check(busy_o === 1'b0 && data_o === 16'hFFFF && ser_o === 1'b1 && sclk_o === 1'b0,
          "R11 reset state", {busy_o, ser_o, sclk_o, data_o}, {3'b010, 16'hFFFF});
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(busy_o === 1'b0, "R1 no start without command", 32'(busy_o), 0);

    for (int i = 0; i < NV; i++) run_conv(V_CODE[i], V_SEL[i], V_CTC[i]);

    // R10 result held while comparator wanders
    held = data_o; bad = 0;
    for (int i = 0; i < 8; i++) begin
      code_r = 16'(i * 16'h2345);
      @(negedge clk_i);
      if (data_o !== held || busy_o !== 1'b0) bad++;
    end
    check(bad == 0, "R10 result hold", 32'(bad), 0);

    // R3 pulse between edges ignored
    @(negedge clk_i) conv_i = 1'b1;
    #1 conv_i = 1'b0;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      if (busy_o !== 1'b0 || data_o !== held) bad++;
    end
    check(bad == 0, "R3 short pulse ignored", 32'(bad), 0);

    // R2 abort mid conversion
    code_r = 16'h5A5A; res_sel_i = 2'd0; ctc_i = 1'b0;
    @(negedge clk_i) conv_i = 1'b1;
    @(negedge clk_i) conv_i = 1'b0;
    repeat (5) @(negedge clk_i);
    check(busy_o === 1'b1, "R1 conversion running", 32'(busy_o), 1);
    conv_i = 1'b1;
    @(negedge clk_i);
    check(busy_o === 1'b0 && data_o === 16'hFFFF && ser_o === 1'b1 && sclk_o === 1'b0,
          "R2 abort clears", {busy_o, ser_o, sclk_o, data_o}, {3'b010, 16'hFFFF});
    conv_i = 1'b0;
    repeat (20) @(negedge clk_i);
    check(busy_o === 1'b0 && data_o === ~16'h5A5A, "R1 restart after abort", 32'(data_o), 32'(~16'h5A5A));

    // R11 asynchronous reset mid conversion
    @(negedge clk_i) conv_i = 1'b1;
    @(negedge clk_i) conv_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5;
    check(busy_o === 1'b0 && data_o === 16'hFFFF && sclk_o === 1'b0 && ser_o === 1'b1,
          "R11 async reset", {busy_o, ser_o, sclk_o, data_o}, {3'b010, 16'hFFFF});
    @(negedge clk_i) rst_ni = 1'b1;

    // R6 after reset, a full run still works at 12 bits
    run_conv(16'hFEDC, 2'd3, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule